// File: doc/BRIEF.md
# Programmable Window Gate Generator

This block produces a periodic counting window for a pulse counter. Its gate output is high for a programmable number of prescaled ticks and then low for a second programmable number of ticks, and that pattern repeats for as long as the block is enabled. Each length is set by a 4-bit field and counts down from sixteen: the length in ticks is sixteen minus the field. A setting of 0 therefore gives the longest phase (16 ticks) and a setting of 15 the shortest (1 tick).

The tick comes from a free-running power-of-two divider of the system clock. A 2-bit select picks one of three taps, and each tap exponent is a parameter. Since the divider never stops, the first high phase after enable waits for the next tick of the chosen tap. Each length setting is captured as its phase begins. A write made while that phase is running takes effect in the next phase of the same kind, so the settings can be updated safely while the gate is low. One-cycle strobes mark each rising and each falling edge of the gate, so a counter can latch its result or clear itself.

Top module: `window_gate_gen`

## Requirements
- R1: While enabled, every high phase of `gate` lasts (16 − `hi_set`) × P clock cycles, where P is the tick period of the selected tap. A setting of 0 gives 16 ticks and a setting of 15 gives 1 tick.
- R2: Every low phase of `gate` between two high phases lasts (16 − `lo_set`) × P clock cycles.
- R3: `tap_sel` code 0 gives P = 2^TAP0_EXP, code 1 gives P = 2^TAP1_EXP, code 2 gives P = 2^TAP2_EXP, and the reserved code 3 behaves like code 2.
- R4: A high phase is always followed by a low phase. `rise_strb` is high for exactly the first cycle in which `gate` is high, and `fall_strb` is high for exactly the first low cycle after a high phase.
- R5: After `en` rises, the first high phase begins between 1 and P cycles later, aligned to the free-running divider.
- R6: `lo_set` is captured when a low phase begins. A change made during a low phase leaves that phase unchanged and applies to the next low phase.
- R7: `hi_set` is captured when a high phase begins. A change made during a high phase applies to the next high phase.
- R8: When `en` is low, `gate` is low in that same cycle, both strobes stay low, and the phase state is cleared. A later enable starts a complete high phase with a `rise_strb`.
- R9: While `rst_n` is low, `gate`, `rise_strb` and `fall_strb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces the gate off |
| hi_set | input | 4 | High-phase setting, length = 16 − value ticks |
| lo_set | input | 4 | Low-phase setting, length = 16 − value ticks |
| tap_sel | input | 2 | Prescaler tap select (3 acts as 2) |
| gate | output | 1 | Window gate level |
| rise_strb | output | 1 | One-cycle strobe on the gate's rising edge |
| fall_strb | output | 1 | One-cycle strobe on the gate's falling edge |

## Verification
Every phase boundary is registered on a divider tick. The gate and its strobe change together one cycle after that tick, so the bench samples at the falling edge and measures each phase as the number of cycles in which `gate` holds its level. That count has to equal exactly (16 − setting) × P. Disabling acts through combinational gating, so the bench checks `gate` one time step after it lowers `en`, before the next rising edge. The delay to the first high phase after enable is not fixed: the bench counts cycles from the enable to the first `rise_strb` and accepts any count from 1 to P.

// File: rtl/wgate_pkg.sv
package wgate_pkg;
  localparam int SET_W = 4;
  localparam int LEN_W = 5;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

  // Phase length in ticks: sixteen minus the setting.
  function automatic logic [LEN_W-1:0] ticks_for(input logic [SET_W-1:0] s);
    return 5'd16 - {1'b0, s};
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/wgate_prescaler.sv
module wgate_prescaler
  import wgate_pkg::*;
#(
  parameter int TAP0_EXP = 12,
  parameter int TAP1_EXP = 13,
  parameter int TAP2_EXP = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tap_sel,
  output logic       tick
);
  localparam int DIV_W = max3(TAP0_EXP, TAP1_EXP, TAP2_EXP);

  logic [DIV_W-1:0] div_q;
  logic [2:0]       tap_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  for (genvar g = 0; g < 3; g++) begin : g_tap
    localparam int EXP = (g == 0) ? TAP0_EXP : (g == 1) ? TAP1_EXP : TAP2_EXP;
    assign tap_hit[g] = &div_q[EXP-1:0];
  end

  always_comb begin
    case (tap_sel)
      2'd0:    tick = tap_hit[0];
      2'd1:    tick = tap_hit[1];
      default: tick = tap_hit[2];
    endcase
  end

  AST_TICK_NOT_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick) && $stable(tap_sel) |-> !tick); // R3
endmodule

// File: rtl/wgate_phase.sv
module wgate_phase
  import wgate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [SET_W-1:0] hi_set,
  input  logic [SET_W-1:0] lo_set,
  output logic             gate_q,
  output logic             rise_q,
  output logic             fall_q
);
  phase_e           phase_q;
  logic [SET_W-1:0] cnt_q;
  logic [LEN_W-1:0] hi_len_q;
  logic [LEN_W-1:0] lo_len_q;
  logic             hi_done;
  logic             lo_done;

  assign hi_done = ({1'b0, cnt_q} == hi_len_q - 5'd1);
  assign lo_done = ({1'b0, cnt_q} == lo_len_q - 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      hi_len_q <= 5'd16;
      lo_len_q <= 5'd16;
      gate_q   <= 1'b0;
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (!en) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
        gate_q  <= 1'b0;
      end else if (tick) begin
        case (phase_q)
          PH_IDLE: begin
            phase_q  <= PH_HIGH;
            hi_len_q <= ticks_for(hi_set);
            cnt_q    <= '0;
            gate_q   <= 1'b1;
            rise_q   <= 1'b1;
          end
          PH_HIGH: begin
            if (hi_done) begin
              phase_q  <= PH_LOW;
              lo_len_q <= ticks_for(lo_set);
              cnt_q    <= '0;
              gate_q   <= 1'b0;
              fall_q   <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_LOW: begin
            if (lo_done) begin
              phase_q  <= PH_HIGH;
              hi_len_q <= ticks_for(hi_set);
              cnt_q    <= '0;
              gate_q   <= 1'b1;
              rise_q   <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  AST_HIGH_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_HIGH |-> {1'b0, cnt_q} < hi_len_q); // R1
  AST_LOW_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_LOW |-> {1'b0, cnt_q} < lo_len_q); // R2
  AST_STEP_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) && (phase_q != $past(phase_q)) |-> $past(tick)); // R5
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> phase_q == PH_IDLE && cnt_q == '0); // R8
endmodule

// File: rtl/window_gate_gen.sv
module window_gate_gen
  import wgate_pkg::*;
#(
  parameter int TAP0_EXP = 12,
  parameter int TAP1_EXP = 13,
  parameter int TAP2_EXP = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] hi_set,
  input  logic [3:0] lo_set,
  input  logic [1:0] tap_sel,
  output logic       gate,
  output logic       rise_strb,
  output logic       fall_strb
);
  logic tick;
  logic gate_q;
  logic rise_q;
  logic fall_q;

  wgate_prescaler #(
    .TAP0_EXP(TAP0_EXP),
    .TAP1_EXP(TAP1_EXP),
    .TAP2_EXP(TAP2_EXP)
  ) u_prescaler (
    .clk    (clk),
    .rst_n  (rst_n),
    .tap_sel(tap_sel),
    .tick   (tick)
  );

  wgate_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .tick  (tick),
    .hi_set(hi_set),
    .lo_set(lo_set),
    .gate_q(gate_q),
    .rise_q(rise_q),
    .fall_q(fall_q)
  );

  assign gate      = gate_q & en;
  assign rise_strb = rise_q & en;
  assign fall_strb = fall_q & en;

  AST_RISE_MARKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_strb |-> gate && !$past(gate)); // R4
  AST_FALL_MARKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_strb |-> !gate && $past(gate)); // R4
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_strb && fall_strb)); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !gate && !rise_strb && !fall_strb); // R9
endmodule

// File: tb/window_gate_gen_bench.sv
module window_gate_gen_bench;
  localparam int E0 = 2;
  localparam int E1 = 3;
  localparam int E2 = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] hi_set = 4'd0;
  logic [3:0] lo_set = 4'd0;
  logic [1:0] tap_sel = 2'd0;
  logic       gate;
  logic       rise_strb;
  logic       fall_strb;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  window_gate_gen #(.TAP0_EXP(E0), .TAP1_EXP(E1), .TAP2_EXP(E2)) u_window_gate_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .hi_set(hi_set), .lo_set(lo_set),
    .tap_sel(tap_sel), .gate(gate), .rise_strb(rise_strb), .fall_strb(fall_strb)
  );

  function automatic int per(input int s);
    if (s == 0) return 1 << E0;
    if (s == 1) return 1 << E1;
    return 1 << E2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!rise_strb && lat < 3000);
  endtask

  // Starts at a negedge with gate just risen; ends at next rise.
  task automatic measure(output int hi, output int lo, output bit fs, output bit rs);
    hi = 0; lo = 0;
    while (gate && hi < 3000) begin hi++; @(negedge clk); end
    fs = fall_strb;
    while (!gate && lo < 3000) begin lo++; @(negedge clk); end
    rs = rise_strb;
  endtask

  task automatic restart(input int s, input int h, input int l);
    int lat;
    @(negedge clk);
    en = 1'b0; tap_sel = 2'(s); hi_set = 4'(h); lo_set = 4'(l);
    repeat (3) @(negedge clk);
    en = 1'b1;
    wait_rise(lat);
  endtask

  task automatic t_reset();
    chk(!gate && !rise_strb && !fall_strb, "R9", int'(gate), 0);
  endtask

  task automatic t_periods(input int s, input int h, input int l, input int pexp);
    int hi, lo; bit fs, rs;
    restart(s, h, l);
    measure(hi, lo, fs, rs);
    chk(hi == (16 - h) * pexp, "R1", hi, (16 - h) * pexp);
    chk(lo == (16 - l) * pexp, "R2", lo, (16 - l) * pexp);
    chk(fs && rs, "R4", int'({fs, rs}), 3);
  endtask

  task automatic t_latency(input int s);
    int lat;
    @(negedge clk);
    en = 1'b0; tap_sel = 2'(s); hi_set = 4'd12; lo_set = 4'd12;
    repeat (5) @(negedge clk);
    en = 1'b1;
    wait_rise(lat);
    chk(lat >= 1 && lat <= per(s), "R5", lat, per(s));
  endtask

  task automatic t_lo_defer();
    int lo1, lo2, hi;
    restart(0, 14, 12);
    while (gate) @(negedge clk);
    lo_set = 4'd14;
    lo1 = 0;
    while (!gate) begin lo1++; @(negedge clk); end
    chk(lo1 == 4 * per(0), "R6 current low", lo1, 4 * per(0));
    hi = 0;
    while (gate) begin hi++; @(negedge clk); end
    lo2 = 0;
    while (!gate) begin lo2++; @(negedge clk); end
    chk(lo2 == 2 * per(0), "R6 next low", lo2, 2 * per(0));
  endtask

  task automatic t_hi_defer();
    int hi1, hi2, lo; bit fs, rs;
    restart(0, 14, 14);
    hi_set = 4'd10;
    measure(hi1, lo, fs, rs);
    chk(hi1 == 2 * per(0), "R7 current high", hi1, 2 * per(0));
    measure(hi2, lo, fs, rs);
    chk(hi2 == 6 * per(0), "R7 next high", hi2, 6 * per(0));
  endtask

  task automatic t_disable();
    int bad, lat, hi, lo; bit fs, rs;
    restart(1, 8, 8);
    repeat (3) @(negedge clk);
    en = 1'b0;
    #1;
    chk(!gate, "R8 immediate", int'(gate), 0);
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (gate || rise_strb || fall_strb) bad++;
    end
    chk(bad == 0, "R8 quiet", bad, 0);
    hi_set = 4'd13;
    en = 1'b1;
    wait_rise(lat);
    chk(lat >= 1 && lat <= per(1), "R8 restart", lat, per(1));
    measure(hi, lo, fs, rs);
    chk(hi == 3 * per(1), "R8 full high", hi, 3 * per(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_periods(0, 5, 9, per(0));    // R1 R2 mid values
    t_periods(0, 0, 15, per(0));   // R1 longest, R2 shortest
    t_periods(0, 15, 0, per(0));   // R1 shortest, R2 longest
    t_periods(1, 12, 10, 1 << E1); // R3 code 1
    t_periods(2, 13, 11, 1 << E2); // R3 code 2
    t_periods(3, 13, 11, 1 << E2); // R3 code 3 acts as 2
    t_latency(0);
    t_latency(2);
    t_lo_defer();
    t_hi_defer();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule